// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line of one small write-back cache that sits on an atomic, broadcast, snooped bus. Each line is in one of four stable states: Invalid, Shared, Exclusive or Modified. Processor loads, stores and evictions arrive on one side. The block answers hits locally and, when the bus is needed, issues the single bus request that the protocol requires. Transactions that other caches place on the bus arrive on the snoop side. The block updates the matching line and, one cycle later, drives the wired-OR response lines: has-copy, holds-dirty, a qualifier that tells the bus the two may be sampled, and a flag that says this cache will supply the data.

The tag/state store is direct-mapped, with 2^IDX_W lines. A bus request is taken to be serialized in the cycle it is issued. The shared wired-OR input is sampled in that same cycle to choose the fill state of a read miss. When a snoop and a processor access hit the same index in one cycle, the snoop is applied first. The processor access is then decided against the state that the snoop leaves behind.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: Encodings are as follows. Line state: 0=I, 1=S, 2=E, 3=M. Processor op: 0=load, 1=store, 2=evict, 3=idle. Bus/snoop command: 0=GETS, 1=GETX, 2=Upgrade, 3=PUTX. An address is {tag, index}, with the index in the low IDX_W bits. After reset every line is I and all snoop response outputs are low.
- R2: A load miss issues GETS on its own address and completes. The line becomes S when `bus_shared_in` is high in that cycle, and E otherwise.
- R3: A load that hits in M, E or S, and a store that hits in M, complete with no bus request and leave the state unchanged.
- R4: A store that hits in E completes with no bus request, and the line becomes M.
- R5: A store that hits in S issues Upgrade, and a store miss issues GETX. Both complete and leave the line in M.
- R6: A snooped GETS that hits moves the line to S. If the line was in M, the response reports dirty and data supply; a line in E or S reports only has-copy.
- R7: A snooped GETX or Upgrade that hits moves the line to I. Data supply is reported only for GETX on a line in M.
- R8: A snooped PUTX changes no line state and never reports data supply.
- R9: One cycle after any snooped transaction, `rsp_valid` is high. `rsp_shared` is high if the snooped line was held (tag match and not I). `rsp_dirty` is high if it was held in M. With no snoop, all three are low.
- R10: An evict that hits in M issues PUTX and leaves the line I. An evict that hits in E or S leaves the line I with no bus request. An evict that misses does nothing. All of these complete.
- R11: A load or store miss whose victim line is in M issues PUTX on the victim's address, invalidates the victim and does not complete. A victim in E or S is dropped silently, and the miss request goes out in the same cycle.
- R12: A snoop and a processor access to the same index in one cycle are resolved snoop first. For example, a store to an S line that is hit by a snooped GETX issues GETX rather than Upgrade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid | input | 1 | Processor access present |
| proc_op | input | 2 | Processor operation |
| proc_addr | input | IDX_W+TAG_W | Processor address |
| proc_done | output | 1 | Access completes this cycle |
| proc_line_st | output | 2 | Next state of the line for `proc_addr` (I when not resident) |
| bus_req_valid | output | 1 | Bus request issued this cycle |
| bus_req_cmd | output | 2 | Bus request command |
| bus_req_addr | output | IDX_W+TAG_W | Bus request address |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | IDX_W+TAG_W | Snooped address |
| rsp_valid | output | 1 | Snoop result may be sampled |
| rsp_shared | output | 1 | This cache held a copy |
| rsp_dirty | output | 1 | This cache held the line in M |
| rsp_supply | output | 1 | This cache supplies the data |

## Verification
The hardest situation to reach from the ports is a snoop and a processor access landing on the same index in the same cycle. The processor's decision must then follow the state the snoop leaves, for example an intended Upgrade turning into GETX, or a load hit in M that ends in S. Directed steps first set up S and M lines and then apply a same-cycle GETX, Upgrade or GETS to each. Random traffic confined to four tags over four indices then makes such collisions and M-victim replacements frequent.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_IDLE = 2'd3} proc_op_t;
  typedef enum logic [1:0] {BC_GETS = 2'd0, BC_GETX = 2'd1, BC_UPGR = 2'd2, BC_PUTX = 2'd3} bus_cmd_t;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES-1:0]             wr_en,
  input  logic [LINES-1:0][TAG_W-1:0]  wr_tag,
  input  logic [LINES-1:0][1:0]        wr_st,
  output logic [LINES-1:0][TAG_W-1:0]  rd_tag,
  output logic [LINES-1:0][1:0]        rd_st
);
  for (genvar i = 0; i < LINES; i++) begin : g_ln
    logic [TAG_W-1:0] tag_q;
    logic [1:0]       st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        st_q  <= LS_I;
      end else if (wr_en[i]) begin
        tag_q <= wr_tag[i];
        st_q  <= wr_st[i];
      end
    end
    assign rd_tag[i] = tag_q;
    assign rd_st[i]  = st_q;
  end
endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
  import mesi_pkg::*;
(
  input  logic     valid,
  input  bus_cmd_t cmd,
  input  logic     tag_eq,
  input  line_st_t cur_st,
  output line_st_t nxt_st,
  output logic     has_copy,
  output logic     is_dirty,
  output logic     supply
);
  always_comb begin
    has_copy = valid && tag_eq && (cur_st != LS_I);
    is_dirty = has_copy && (cur_st == LS_M);
    supply   = is_dirty && (cmd == BC_GETS || cmd == BC_GETX);
    nxt_st   = cur_st;
    if (has_copy) begin
      case (cmd)
        BC_GETS:          nxt_st = LS_S;
        BC_GETX, BC_UPGR: nxt_st = LS_I;
        default:          nxt_st = cur_st;   // another cache's PUTX: no action
      endcase
    end
  end
endmodule

// File: rtl/mesi_proc_eval.sv
module mesi_proc_eval
  import mesi_pkg::*;
(
  input  logic     act,
  input  proc_op_t op,
  input  logic     tag_eq,
  input  line_st_t cur_st,
  input  logic     shared_in,
  output line_st_t nxt_st,
  output logic     alloc,
  output logic     victim,
  output logic     bus_valid,
  output bus_cmd_t bus_cmd,
  output logic     done
);
  logic hit;
  assign hit = tag_eq && (cur_st != LS_I);

  always_comb begin
    nxt_st    = cur_st;
    alloc     = 1'b0;
    victim    = 1'b0;
    bus_valid = 1'b0;
    bus_cmd   = BC_GETS;
    done      = 1'b0;
    if (act) begin
      case (op)
        OP_LOAD, OP_STORE: begin
          if (hit) begin
            done = 1'b1;
            if (op == OP_STORE && cur_st == LS_E) begin
              nxt_st = LS_M;
            end else if (op == OP_STORE && cur_st == LS_S) begin
              nxt_st    = LS_M;
              bus_valid = 1'b1;
              bus_cmd   = BC_UPGR;
            end
          end else if (cur_st == LS_M) begin
            // dirty victim must reach memory first; access retried later
            victim    = 1'b1;
            nxt_st    = LS_I;
            bus_valid = 1'b1;
            bus_cmd   = BC_PUTX;
          end else begin
            alloc     = 1'b1;
            done      = 1'b1;
            bus_valid = 1'b1;
            if (op == OP_LOAD) begin
              bus_cmd = BC_GETS;
              nxt_st  = shared_in ? LS_S : LS_E;
            end else begin
              bus_cmd = BC_GETX;
              nxt_st  = LS_M;
            end
          end
        end
        OP_EVICT: begin
          done = 1'b1;
          if (hit) begin
            nxt_st = LS_I;
            if (cur_st == LS_M) begin
              bus_valid = 1'b1;
              bus_cmd   = BC_PUTX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    proc_valid,
  input  logic [1:0]              proc_op,
  input  logic [IDX_W+TAG_W-1:0]  proc_addr,
  output logic                    proc_done,
  output logic [1:0]              proc_line_st,
  output logic                    bus_req_valid,
  output logic [1:0]              bus_req_cmd,
  output logic [IDX_W+TAG_W-1:0]  bus_req_addr,
  input  logic                    bus_shared_in,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [IDX_W+TAG_W-1:0]  snp_addr,
  output logic                    rsp_valid,
  output logic                    rsp_shared,
  output logic                    rsp_dirty,
  output logic                    rsp_supply
);
  localparam int ADDR_W = IDX_W + TAG_W;
  localparam int LINES  = 1 << IDX_W;

  logic [LINES-1:0]            wr_en;
  logic [LINES-1:0][TAG_W-1:0] wr_tag;
  logic [LINES-1:0][1:0]       wr_st;
  logic [LINES-1:0][TAG_W-1:0] rd_tag;
  logic [LINES-1:0][1:0]       rd_st;

  mesi_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag), .wr_st(wr_st),
    .rd_tag(rd_tag), .rd_st(rd_st)
  );

  // snoop side
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  line_st_t         s_cur, s_nxt;
  logic             s_has, s_dirty, s_supply;
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_cur = line_st_t'(rd_st[s_idx]);

  mesi_snoop_eval u_snp (
    .valid(snp_valid), .cmd(bus_cmd_t'(snp_cmd)), .tag_eq(rd_tag[s_idx] == s_tag),
    .cur_st(s_cur), .nxt_st(s_nxt), .has_copy(s_has), .is_dirty(s_dirty), .supply(s_supply)
  );

  // processor side, evaluated after the snoop on a shared index
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag;
  logic             p_act, p_tag_eq, p_alloc, p_victim, p_bus_v, p_done;
  line_st_t         p_cur, p_nxt;
  bus_cmd_t         p_cmd;
  assign p_idx    = proc_addr[IDX_W-1:0];
  assign p_tag    = proc_addr[ADDR_W-1:IDX_W];
  assign p_act    = proc_valid && (proc_op_t'(proc_op) != OP_IDLE);
  assign p_tag_eq = (rd_tag[p_idx] == p_tag);
  assign p_cur    = (snp_valid && s_idx == p_idx) ? s_nxt : line_st_t'(rd_st[p_idx]);

  mesi_proc_eval u_prc (
    .act(p_act), .op(proc_op_t'(proc_op)), .tag_eq(p_tag_eq), .cur_st(p_cur),
    .shared_in(bus_shared_in), .nxt_st(p_nxt), .alloc(p_alloc), .victim(p_victim),
    .bus_valid(p_bus_v), .bus_cmd(p_cmd), .done(p_done)
  );

  // per-line write selection: processor result overrides snoop result
  for (genvar i = 0; i < LINES; i++) begin : g_wr
    logic p_sel, s_sel;
    assign p_sel     = p_act && (p_idx == IDX_W'(i));
    assign s_sel     = s_has && (s_idx == IDX_W'(i));
    assign wr_en[i]  = p_sel || s_sel;
    assign wr_st[i]  = p_sel ? p_nxt : s_nxt;
    assign wr_tag[i] = (p_sel && p_alloc) ? p_tag : rd_tag[i];
  end

  assign proc_done     = p_done;
  assign proc_line_st  = (p_alloc || p_tag_eq) ? p_nxt : LS_I;
  assign bus_req_valid = p_bus_v;
  assign bus_req_cmd   = p_cmd;
  assign bus_req_addr  = p_victim ? {rd_tag[p_idx], p_idx} : proc_addr;

  // snoop response, one cycle after the snooped transaction
  logic rsp_valid_d, rsp_shared_d, rsp_dirty_d, rsp_supply_d;
  always_comb begin
    rsp_valid_d  = snp_valid;
    rsp_shared_d = s_has;
    rsp_dirty_d  = s_dirty;
    rsp_supply_d = s_supply;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_shared <= 1'b0;
      rsp_dirty  <= 1'b0;
      rsp_supply <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_shared <= rsp_shared_d;
      rsp_dirty  <= rsp_dirty_d;
      rsp_supply <= rsp_supply_d;
    end
  end
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk
  import mesi_pkg::*;
#(
  parameter int LINES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  proc_valid,
  input logic [1:0]            proc_op,
  input logic                  proc_done,
  input logic [1:0]            proc_line_st,
  input logic                  bus_req_valid,
  input logic [1:0]            bus_req_cmd,
  input logic                  bus_shared_in,
  input logic                  snp_valid,
  input logic [1:0]            snp_cmd,
  input logic                  rsp_valid,
  input logic                  rsp_shared,
  input logic                  rsp_dirty,
  input logic                  rsp_supply,
  input logic [LINES-1:0][1:0] lines_st
);
  logic p_act;
  assign p_act = proc_valid && (proc_op != OP_IDLE);

  AST_DIRTY_HAS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dirty |-> rsp_shared); // R9
  AST_SUPPLY_IS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_supply |-> rsp_dirty); // R6
  AST_COPY_IS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_shared |-> rsp_valid); // R9
  AST_RSP_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(snp_valid)); // R9
  AST_PUTX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_PUTX && !p_act) |=> $stable(lines_st)); // R8
  AST_SILENT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_valid && proc_op == OP_STORE && proc_done && !bus_req_valid) |-> proc_line_st == LS_M); // R4
  AST_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_GETS) |-> proc_line_st == (bus_shared_in ? LS_S : LS_E)); // R2
  AST_VICTIM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_PUTX && proc_op != OP_EVICT) |-> !proc_done); // R11
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_op(proc_op),
  .proc_done(proc_done), .proc_line_st(proc_line_st), .bus_req_valid(bus_req_valid),
  .bus_req_cmd(bus_req_cmd), .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .rsp_valid(rsp_valid), .rsp_shared(rsp_shared),
  .rsp_dirty(rsp_dirty), .rsp_supply(rsp_supply), .lines_st(rd_st)
);

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;
  localparam int IW = 2;
  localparam int TW = 6;
  localparam int AW = IW + TW;
  localparam int NL = 1 << IW;

  logic          clk, rst_n;
  logic          proc_valid, proc_done, bus_req_valid, bus_shared_in, snp_valid;
  logic [1:0]    proc_op, proc_line_st, bus_req_cmd, snp_cmd;
  logic [AW-1:0] proc_addr, bus_req_addr, snp_addr;
  logic          rsp_valid, rsp_shared, rsp_dirty, rsp_supply;

  mesi_snoop_ctrl #(.IDX_W(IW), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_valid(proc_valid), .proc_op(proc_op),
    .proc_addr(proc_addr), .proc_done(proc_done), .proc_line_st(proc_line_st),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .rsp_valid(rsp_valid), .rsp_shared(rsp_shared),
    .rsp_dirty(rsp_dirty), .rsp_supply(rsp_supply)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench reference: state 0=I 1=S 2=E 3=M
  logic [TW-1:0] mt [NL];
  logic [1:0]    ms [NL];
  logic pv_v, pv_sh, pv_dt, pv_sp;
  string pv_lbl = "R1";

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ad(input int t, input int i);
    logic [TW-1:0] tt = TW'(t);
    logic [IW-1:0] ii = IW'(i);
    return {tt, ii};
  endfunction

  task automatic step(input bit pv, input int op, input logic [AW-1:0] pa,
                      input bit sv, input int sc, input logic [AW-1:0] sa, input bit sh);
    int si, pi, st;
    logic [TW-1:0] stg, ptg;
    bit shit, teq, hit;
    bit e_done, e_bv;
    int e_cmd;
    logic [AW-1:0] e_addr;
    string lbl;
    @(negedge clk);
    // response for the previous cycle's snoop (R9)
    chk("R9", "rsp_valid", int'(rsp_valid), int'(pv_v));
    chk("R9", "rsp_shared", int'(rsp_shared), int'(pv_sh));
    chk("R9", "rsp_dirty", int'(rsp_dirty), int'(pv_dt));
    chk(pv_lbl, "rsp_supply", int'(rsp_supply), int'(pv_sp));
    proc_valid = pv; proc_op = 2'(op); proc_addr = pa;
    snp_valid = sv; snp_cmd = 2'(sc); snp_addr = sa; bus_shared_in = sh;
    // snoop first
    si = int'(sa[IW-1:0]); stg = sa[AW-1:IW];
    shit = sv && ms[si] != 2'd0 && mt[si] == stg;
    pv_v = sv; pv_sh = shit; pv_dt = shit && ms[si] == 2'd3;
    pv_sp = pv_dt && (sc == 0 || sc == 1);
    pv_lbl = (sc == 0) ? "R6" : ((sc == 3) ? "R8" : "R7");
    if (!sv) pv_lbl = "R9";
    lbl = sv ? pv_lbl : "R1";
    if (shit) begin
      if (sc == 0) ms[si] = 2'd1;
      else if (sc == 1 || sc == 2) ms[si] = 2'd0;
    end
    // processor against post-snoop state
    pi = int'(pa[IW-1:0]); ptg = pa[AW-1:IW];
    st = int'(ms[pi]); teq = (mt[pi] == ptg); hit = teq && st != 0;
    e_done = 0; e_bv = 0; e_cmd = 0; e_addr = pa;
    if (pv && op != 3) begin
      if (op == 2) begin
        lbl = "R10"; e_done = 1;
        if (hit) begin
          if (st == 3) begin e_bv = 1; e_cmd = 3; end
          ms[pi] = 2'd0;
        end
      end else if (hit) begin
        e_done = 1;
        if (op == 1 && st == 2) begin lbl = "R4"; ms[pi] = 2'd3; end
        else if (op == 1 && st == 1) begin lbl = "R5"; e_bv = 1; e_cmd = 2; ms[pi] = 2'd3; end
        else lbl = "R3";
      end else if (st == 3) begin
        lbl = "R11"; e_bv = 1; e_cmd = 3; e_addr = {mt[pi], pa[IW-1:0]}; ms[pi] = 2'd0;
      end else begin
        e_done = 1; e_bv = 1; mt[pi] = ptg;
        if (op == 0) begin lbl = (st != 0) ? "R11" : "R2"; e_cmd = 0; ms[pi] = sh ? 2'd1 : 2'd2; end
        else begin lbl = (st != 0) ? "R11" : "R5"; e_cmd = 1; ms[pi] = 2'd3; end
      end
      if (sv && si == pi) lbl = "R12";
    end
    #1;
    chk(lbl, "proc_done", int'(proc_done), int'(e_done));
    chk(lbl, "bus_req_valid", int'(bus_req_valid), int'(e_bv));
    if (e_bv) begin
      chk(lbl, "bus_req_cmd", int'(bus_req_cmd), e_cmd);
      chk(lbl, "bus_req_addr", int'(bus_req_addr), int'(e_addr));
    end
    chk(lbl, "proc_line_st", int'(proc_line_st), (mt[pi] == ptg) ? int'(ms[pi]) : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NL; i++) begin mt[i] = '0; ms[i] = 2'd0; end
    pv_v = 0; pv_sh = 0; pv_dt = 0; pv_sp = 0;
    rst_n = 1'b0; proc_valid = 0; proc_op = 2'd3; proc_addr = '0;
    snp_valid = 0; snp_cmd = 2'd0; snp_addr = '0; bus_shared_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    step(0, 3, ad(0, 0), 0, 0, 0, 0);
    step(0, 3, ad(0, 3), 0, 0, 0, 0);
    // R2 fills
    step(1, 0, ad(1, 0), 0, 0, 0, 0);
    step(1, 0, ad(2, 1), 0, 0, 0, 1);
    // R3 hit, R4 silent, R5 upgrade and GETX
    step(1, 0, ad(1, 0), 0, 0, 0, 0);
    step(1, 1, ad(1, 0), 0, 0, 0, 0);
    step(1, 1, ad(2, 1), 0, 0, 0, 0);
    step(1, 1, ad(3, 2), 0, 0, 0, 0);
    // R6 snooped GETS on M then on S
    step(0, 3, ad(1, 0), 1, 0, ad(1, 0), 0);
    step(0, 3, ad(1, 0), 1, 0, ad(1, 0), 0);
    // R7 snooped GETX on M
    step(0, 3, ad(2, 1), 1, 1, ad(2, 1), 0);
    // R8 snooped PUTX leaves M alone
    step(0, 3, ad(3, 2), 1, 3, ad(3, 2), 0);
    step(1, 0, ad(3, 2), 0, 0, 0, 0);
    // R10 evicts
    step(1, 2, ad(3, 2), 0, 0, 0, 0);
    step(1, 2, ad(3, 2), 0, 0, 0, 0);
    // R11 dirty victim, retry, clean victim
    step(1, 1, ad(1, 0), 0, 0, 0, 0);
    step(1, 0, ad(5, 0), 0, 0, 0, 0);
    step(1, 0, ad(5, 0), 0, 0, 0, 0);
    step(1, 0, ad(6, 0), 0, 0, 0, 1);
    // R12 same-index collisions
    step(1, 0, ad(2, 1), 0, 0, 0, 1);
    step(1, 1, ad(2, 1), 1, 1, ad(2, 1), 0);
    step(1, 0, ad(2, 1), 1, 0, ad(2, 1), 0);
    step(1, 1, ad(6, 0), 1, 2, ad(6, 0), 0);
    // constrained random traffic on four tags
    for (int n = 0; n < 3000; n++) begin
      step(bit'($urandom_range(1)), int'($urandom_range(3)),
           ad(int'($urandom_range(3)), int'($urandom_range(NL - 1))),
           bit'($urandom_range(1)), int'($urandom_range(3)),
           ad(int'($urandom_range(3)), int'($urandom_range(NL - 1))),
           bit'($urandom_range(1)));
    end
    step(0, 3, ad(0, 0), 0, 0, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule